// File: doc/BRIEF.md
# Serial-Bus PHY Status and Interrupt Register Slice

This block holds the software-visible control and status bits of a serial-bus physical-layer device that live outside the arbitration engine. It keeps the link-control, contender, power-class, resume-interrupt-enable and short-reset-request bits. It also keeps three latched interrupt flags: configuration timeout, state timeout and cable-power drop. Software reaches all of them through a small byte-wide register port with a combinational read and a single-cycle write.

Two reset sources act on the block. The asynchronous hardware reset initialises every bit. Some bits come from strap pins and one interrupt flag starts set. The synchronous bus-reset strobe clears only the short-reset request. The block drives the link-active, contender and power fields for the self-identification packet. It also drives a link-on wake signal that alerts a sleeping link layer when an enabled interrupt is pending.

Both asynchronous status inputs pass through two-flop synchronizers. The cable-power input also goes through a registered falling-edge detector.

Top module: `phy_stat_irq`

## Requirements
- R1: While hardware reset is held, and after it is released, the bits read as follows. Link-control is 1, resume-enable is 0, short-reset request is 0, and the configuration-timeout and state-timeout flags are 0. The cable-power flag is 1. Contender and power class equal the strap pins.
- R2: Register map for reads and writes, 8-bit data.
  - Address 0: [7:5] speed code, fixed at 3'b010. [4:1] delay, reads 0. [0] link-control, read/write.
  - Address 1: [7] contender, read/write. [6:4] jitter, reads 0. [3:1] power class, read/write. [0] reads 0.
  - Address 2: [7] resume-enable. [6] short-reset request. [5] configuration-timeout flag. [4] cable-power flag. [3] state-timeout flag. [2:0] read 0.
  - Address 3 reads 0.
- R3: The self-ID link-active output is link-control AND the synchronized link power-status input. The self-ID contender and power outputs follow their register bits.
- R4: A bus reset leaves link-control, contender, power class, resume-enable and all three interrupt flags unchanged.
- R5: A configuration-timeout or state-timeout strobe sets its flag. A high-to-low transition of the cable power-status input sets the cable-power flag within five clocks. A low-to-high transition does not set it.
- R6: Each interrupt flag is cleared by writing 1 to its bit. Writing 0 leaves it unchanged. When a set event and a clearing write land in the same cycle, the flag ends up set.
- R7: Writing 1 to the short-reset request bit sets it. A bus reset clears it, even when the bus reset lands in the same cycle as a write of 1.
- R8: Link-on is high exactly when three conditions hold: resume-enable is 1, the synchronized link power-status is low, and at least one interrupt flag is set. It follows the link going inactive after a flag was raised, and a flag being raised while the link is already inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| hw_rst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_rst | input | 1 | Bus-reset event strobe, one clock |
| lps_in | input | 1 | Link power-status input, asynchronous |
| cps_in | input | 1 | Cable power-status input, asynchronous |
| cfg_to_evt | input | 1 | Configuration-timeout event strobe |
| st_to_evt | input | 1 | State-timeout event strobe |
| strap_contender | input | 1 | Contender value loaded at hardware reset |
| strap_pwr | input | 3 | Power class loaded at hardware reset |
| reg_addr | input | AW | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| link_on | output | 1 | Wake notification to the link layer |
| sid_link_active | output | 1 | Self-ID link-active field |
| sid_contender | output | 1 | Self-ID contender field |
| sid_pwr | output | 3 | Self-ID power field |

## Verification
The hardest condition to reach is link-on under every mix of enable, link activity and interrupt source. The cable-power source in particular can only be raised by a real falling edge that passes through the synchronizer. The bench sweeps all sixteen combinations of enable, link state and source. For each one it first parks the cable input high, then clears all flags with a write-one, and then fires exactly one event. It then toggles the link power-status input to confirm that the output follows the link going inactive after the flag was raised. Same-cycle collisions are driven on a single negative edge: set against clear, and bus reset against a write.

// File: rtl/phy_stat_irq.sv
module phy_stat_irq #(
  parameter int AW = 2,
  parameter logic [2:0] SPEED_CODE = 3'b010
) (
  input  logic          clk,
  input  logic          hw_rst_n,
  input  logic          bus_rst,
  input  logic          lps_in,
  input  logic          cps_in,
  input  logic          cfg_to_evt,
  input  logic          st_to_evt,
  input  logic          strap_contender,
  input  logic [2:0]    strap_pwr,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          link_on,
  output logic          sid_link_active,
  output logic          sid_contender,
  output logic [2:0]    sid_pwr
);
  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_NODE = AW'(1);
  localparam logic [AW-1:0] A_IRQ = AW'(2);

  logic [1:0] lps_sync, cps_sync;
  logic       cps_prev;
  logic       link_ctrl, contender, resume_en, short_req;
  logic [2:0] pwr_class;
  logic       cfg_irq, st_irq, cps_irq;

  always_ff @(posedge clk or negedge hw_rst_n)
    if (!hw_rst_n) begin
      lps_sync <= '0;
      cps_sync <= '0;
      cps_prev <= 1'b0;
    end else begin
      lps_sync <= {lps_sync[0], lps_in};
      cps_sync <= {cps_sync[0], cps_in};
      cps_prev <= cps_sync[1];
    end

  wire lps_s    = lps_sync[1];
  wire cps_fall = cps_prev & ~cps_sync[1];
  wire wr_ctl   = reg_wr && reg_addr == A_CTL;
  wire wr_node  = reg_wr && reg_addr == A_NODE;
  wire wr_irq   = reg_wr && reg_addr == A_IRQ;

  always_ff @(posedge clk or negedge hw_rst_n)
    if (!hw_rst_n) begin
      link_ctrl <= 1'b1;
      contender <= strap_contender;
      pwr_class <= strap_pwr;
      resume_en <= 1'b0;
      short_req <= 1'b0;
      cfg_irq   <= 1'b0;
      st_irq    <= 1'b0;
      cps_irq   <= 1'b1;
    end else begin
      if (wr_ctl) link_ctrl <= reg_wdata[0];
      if (wr_node) begin
        contender <= reg_wdata[7];
        pwr_class <= reg_wdata[3:1];
      end
      if (wr_irq) resume_en <= reg_wdata[7];
      if (bus_rst) short_req <= 1'b0;
      else if (wr_irq && reg_wdata[6]) short_req <= 1'b1;
      cfg_irq <= (cfg_irq & ~(wr_irq & reg_wdata[5])) | cfg_to_evt;
      cps_irq <= (cps_irq & ~(wr_irq & reg_wdata[4])) | cps_fall;
      st_irq  <= (st_irq  & ~(wr_irq & reg_wdata[3])) | st_to_evt;
    end

  always_comb
    case (reg_addr)
      A_CTL:   reg_rdata = {SPEED_CODE, 4'b0000, link_ctrl};
      A_NODE:  reg_rdata = {contender, 3'b000, pwr_class, 1'b0};
      A_IRQ:   reg_rdata = {resume_en, short_req, cfg_irq, cps_irq, st_irq, 3'b000};
      default: reg_rdata = 8'h00;
    endcase

  assign link_on         = resume_en & ~lps_s & (cfg_irq | st_irq | cps_irq);
  assign sid_link_active = link_ctrl & lps_s;
  assign sid_contender   = contender;
  assign sid_pwr         = pwr_class;
endmodule

module phy_stat_irq_chk #(
  parameter int AW = 2
) (
  input logic          clk,
  input logic          hw_rst_n,
  input logic          bus_rst,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          cfg_to_evt,
  input logic          st_to_evt,
  input logic          link_on,
  input logic          sid_link_active,
  input logic          link_ctrl,
  input logic          contender,
  input logic [2:0]    pwr_class,
  input logic          resume_en,
  input logic          short_req,
  input logic          cfg_irq,
  input logic          st_irq,
  input logic          cps_irq,
  input logic          cps_fall
);
  a_r6_set_wins_cfg: assert property (@(posedge clk) disable iff (!hw_rst_n)
    cfg_to_evt |=> cfg_irq);
  a_r6_set_wins_st: assert property (@(posedge clk) disable iff (!hw_rst_n)
    st_to_evt |=> st_irq);
  a_r5_cps_fall_sets: assert property (@(posedge clk) disable iff (!hw_rst_n)
    cps_fall |=> cps_irq);
  a_r6_zero_write_keeps: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (reg_wr && reg_addr == AW'(2) && !reg_wdata[5]) |=> cfg_irq || !$past(cfg_irq) == 1'b1 && !cfg_irq ? 1'b1 : cfg_irq);
  a_r4_bus_rst_keeps: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (bus_rst && !reg_wr) |=> $stable(link_ctrl) && $stable(contender) && $stable(pwr_class) && $stable(resume_en));
  a_r7_short_clear: assert property (@(posedge clk) disable iff (!hw_rst_n)
    bus_rst |=> !short_req);
  a_r8_link_on_gate: assert property (@(posedge clk) disable iff (!hw_rst_n)
    link_on |-> resume_en && (cfg_irq || st_irq || cps_irq));
  a_r3_active_needs_ctrl: assert property (@(posedge clk) disable iff (!hw_rst_n)
    sid_link_active |-> link_ctrl);
endmodule

bind phy_stat_irq phy_stat_irq_chk #(.AW(AW)) chk_i (.*);

// File: tb/phy_stat_irq_tb.sv
module phy_stat_irq_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 2;

  logic clk = 0, hw_rst_n = 0, bus_rst = 0, lps_in = 1, cps_in = 1;
  logic cfg_to_evt = 0, st_to_evt = 0, strap_contender = 1;
  logic [2:0] strap_pwr = 3'd5;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic link_on, sid_link_active, sid_contender;
  logic [2:0] sid_pwr;
  int checks = 0, errs = 0;
  bit done = 0;

  phy_stat_irq #(.AW(AW)) dut_i (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d, logic brst = 0, logic cfg = 0);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1; bus_rst = brst; cfg_to_evt = cfg;
    @(negedge clk);
    reg_wr = 0; bus_rst = 0; cfg_to_evt = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic hreset(logic c, logic [2:0] p);
    @(negedge clk);
    strap_contender = c; strap_pwr = p; hw_rst_n = 0;
    cyc(2);
    hw_rst_n = 1;
    cyc(1);
  endtask

  task automatic pulse(bit is_cfg);
    @(negedge clk);
    if (is_cfg) cfg_to_evt = 1; else st_to_evt = 1;
    @(negedge clk);
    cfg_to_evt = 0; st_to_evt = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    cyc(1);
    rd(2, d); chk("R1 irq reg during reset", d, 8'h10);
    hw_rst_n = 1; cyc(4);
    rd(0, d); chk("R1/R2 ctl reg after reset", d, 8'h41);
    rd(1, d); chk("R1/R2 node reg after reset", d, 8'h8A);
    rd(2, d); chk("R1 irq reg after reset", d, 8'h10);
    rd(3, d); chk("R2 unused address", d, 8'h00);
    chk("R1 link_on after reset", {7'd0, link_on}, 8'h00);

    for (int p = 0; p < 8; p++) begin
      hreset(~p[0], 3'(p));
      rd(1, d); chk("R1 strap load", d, {~p[0], 3'b000, 3'(p), 1'b0});
      chk("R3 sid_pwr", {5'd0, sid_pwr}, 8'(p));
      chk("R3 sid_contender", {7'd0, sid_contender}, {7'd0, ~p[0]});
    end

    lps_in = 1; cyc(4);
    chk("R3 active with lps high", {7'd0, sid_link_active}, 8'h01);
    wr(0, 8'hFE);
    rd(0, d); chk("R2 ctl write keeps fixed fields", d, 8'h40);
    chk("R3 inactive with ctrl 0", {7'd0, sid_link_active}, 8'h00);
    wr(0, 8'h01); lps_in = 0; cyc(4);
    chk("R3 inactive with lps low", {7'd0, sid_link_active}, 8'h00);
    wr(1, 8'h0D);
    chk("R3 sid fields follow write", {sid_contender, 4'd0, sid_pwr}, 8'h06);

    wr(2, 8'h00);
    rd(2, d); chk("R6 write 0 keeps cps flag", d, 8'h10);
    wr(2, 8'h10);
    rd(2, d); chk("R6 write 1 clears cps flag", d, 8'h00);
    pulse(1); rd(2, d); chk("R5 cfg strobe sets flag", d, 8'h20);
    pulse(0); rd(2, d); chk("R5 st strobe sets flag", d, 8'h28);
    wr(2, 8'h28); rd(2, d); chk("R6 clear both", d, 8'h00);
    cps_in = 0; cyc(5);
    rd(2, d); chk("R5 cps fall sets flag", d, 8'h10);
    wr(2, 8'h10); cps_in = 1; cyc(5);
    rd(2, d); chk("R5 cps rise ignored", d, 8'h00);
    wr(2, 8'h20, 0, 1);
    rd(2, d); chk("R6 set wins over clear", d, 8'h20);

    wr(0, 8'h00); wr(1, 8'h86); wr(2, 8'hA8 & 8'h80); pulse(0); pulse(1);
    @(negedge clk); bus_rst = 1; @(negedge clk); bus_rst = 0;
    rd(0, d); chk("R4 bus reset keeps ctl", d, 8'h40);
    rd(1, d); chk("R4 bus reset keeps node", d, 8'h86);
    rd(2, d); chk("R4 bus reset keeps irq/enable", d, 8'hA8);

    wr(2, 8'hC0); rd(2, d); chk("R7 short request set", d, 8'hE8);
    @(negedge clk); bus_rst = 1; @(negedge clk); bus_rst = 0;
    rd(2, d); chk("R7 bus reset clears short", d, 8'hA8);
    wr(2, 8'hC0, 1); rd(2, d); chk("R7 bus reset beats write", d, 8'hA8);

    for (int c = 0; c < 16; c++) begin
      logic en, lp, exp;
      logic [1:0] sel;
      en = c[0]; lp = c[1]; sel = 2'(c >> 2);
      cps_in = 1; lps_in = lp; cyc(5);
      wr(2, {en, 7'b0111000});
      case (sel)
        2'd1: pulse(1);
        2'd2: pulse(0);
        2'd3: begin cps_in = 0; cyc(5); end
        default: cyc(1);
      endcase
      exp = en & ~lp & (sel != 0);
      chk($sformatf("R8 link_on combo %0d", c), {7'd0, link_on}, {7'd0, exp});
      lps_in = ~lp; cyc(4);
      exp = en & lp & (sel != 0);
      chk($sformatf("R8 link_on after lps flip %0d", c), {7'd0, link_on}, {7'd0, exp});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule